// File: doc/BRIEF.md
# Configurable Format Serial Transmitter

This block turns bytes into asynchronous serial frames on a single output line. A byte enters through a one-entry holding register. From there a shift engine sends it as a start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and a stop period. A 7-bit line control input sets the frame format. It picks the character length, one stop bit or a longer stop period, parity on or off, even or odd parity, constant ("stuck") parity, and a forced break level.

The block has no baud generator of its own. An enable input pulses once per sixteenth of a bit, and every bit lasts 16 of these pulses. The holding register has a valid/ready write port. A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is high exactly while the holding register is empty. A source that sees `wr_ready` low must keep its byte and wait; a `wr_valid` during that time changes nothing. The shift engine takes the held byte as soon as it is idle, or on the tick that ends a stop period, so consecutive characters follow with no idle time between them.

The format bits 5:0 are captured when a character is taken into the shift engine. The break bit acts on the line at once.

Top module: `uart_fmt_tx`

## Requirements
- R1: After synchronous reset `txd` is 1, and `hold_empty`, `shift_empty` and `wr_ready` are all 1.
- R2: `line_ctl[1:0]` sets the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7, 3 gives 8.
- R3: A frame begins with a start bit at level 0, and data follows least significant bit first. Each bit lasts 16 tick pulses.
- R4: With `line_ctl[2]` = 0 the stop period is one bit at level 1, lasting 16 ticks.
- R5: With `line_ctl[2]` = 1 and 5 data bits the stop period lasts 24 ticks.
- R6: With `line_ctl[2]` = 1 and 6, 7 or 8 data bits the stop period lasts 32 ticks.
- R7: `line_ctl[3]` = 1 inserts a parity bit after the last data bit. With `line_ctl[4]` = 1 the count of ones over the data and parity bits is even; with `line_ctl[4]` = 0 it is odd.
- R8: With `line_ctl[3]` and `line_ctl[5]` both 1 the parity bit is a constant: 0 when `line_ctl[4]` = 1 and 1 when `line_ctl[4]` = 0.
- R9: While `line_ctl[6]` = 1, `txd` is 0. The frame keeps advancing underneath, and clearing the bit shows the current frame level again.
- R10: A byte is accepted only on an edge with `wr_valid` and `wr_ready` both high. `wr_ready` is low while a byte is held, and a `wr_valid` during that time leaves the held byte unchanged.
- R11: `hold_empty` rises when the shift engine takes the held byte. A held byte's start bit begins on the tick that ends the previous stop period.
- R12: Format bits 5:0 are sampled when a character is taken. A change during a frame affects only the next character.
- R13: `shift_empty` is 0 from the moment a character is taken until its stop period ends with nothing held, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_ctl | input | 7 | Format: [1:0] length, [2] long stop, [3] parity on, [4] even, [5] stuck parity, [6] break |
| tick16 | input | 1 | One pulse per sixteenth of a bit |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Holding register can accept a byte |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output, idle level 1 |
| hold_empty | output | 1 | Holding register is empty |
| shift_empty | output | 1 | Shift engine is idle |

## Verification
The bench sweeps all 64 values of format bits 5:0, sending two characters back to back in each run. It switches the control input in the middle of the first frame, which separates a design that latches the format at load from one that follows the live input. A run over all 256 byte values with 8-bit even parity separates correct parity and bit order from near misses. A run with one tick every third clock shows whether timing is counted in ticks or in clocks. A run that sets break over the middle of a frame of ones, together with a write attempted while the holding register is full, tells a frozen or corrupted shifter apart from one that keeps running.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam int UFT_NB_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } tx_state_e;

  typedef enum logic [1:0] {
    STOP_ONE, STOP_ONE_HALF, STOP_TWO
  } stop_len_e;

  typedef struct packed {
    logic [UFT_NB_W-1:0] nbits;
    logic                par_en;
    logic                par_bit;
    stop_len_e           stop;
  } frame_cfg_t;
endpackage

// File: rtl/uft_fmt_decode.sv
module uft_fmt_decode
  import uft_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [1:0]    len_sel,
  input  logic          long_stop,
  input  logic          par_on,
  input  logic          par_even,
  input  logic          par_stuck,
  input  logic [DW-1:0] data,
  output frame_cfg_t    cfg
);
  localparam int MIN_BITS = DW - 3;

  logic [UFT_NB_W-1:0] nb;
  logic [DW-1:0]       masked;

  always_comb begin
    nb = UFT_NB_W'(MIN_BITS) + UFT_NB_W'(len_sel);
    for (int i = 0; i < DW; i++) begin
      masked[i] = data[i] & (UFT_NB_W'(i) < nb);
    end
    cfg.nbits  = nb;
    cfg.par_en = par_on;
    if (par_stuck) cfg.par_bit = ~par_even;
    else           cfg.par_bit = (^masked) ^ ~par_even;
    if (!long_stop)                         cfg.stop = STOP_ONE;
    else if (nb == UFT_NB_W'(MIN_BITS))     cfg.stop = STOP_ONE_HALF;
    else                                    cfg.stop = STOP_TWO;
  end
endmodule

// File: rtl/uft_hold.sv
module uft_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  input  logic          take,
  output logic [DW-1:0] hold_data,
  output logic          hold_full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (wr_valid && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

  assign wr_ready = ~hold_full;
endmodule

// File: rtl/uft_shift.sv
module uft_shift
  import uft_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  frame_cfg_t    cfg_in,
  output logic          take,
  output logic          line,
  output logic          busy
);
  localparam int CW = $clog2(2 * OS + 1);
  localparam logic [CW-1:0] LAST_BIT  = CW'(OS - 1);
  localparam logic [CW-1:0] LAST_ONE  = CW'(OS - 1);
  localparam logic [CW-1:0] LAST_HALF = CW'(OS + OS / 2 - 1);
  localparam logic [CW-1:0] LAST_TWO  = CW'(2 * OS - 1);

  tx_state_e           state;
  logic [CW-1:0]       cnt;
  logic [CW-1:0]       last;
  logic [DW-1:0]       sh;
  logic [UFT_NB_W-1:0] bidx;
  frame_cfg_t          cfg_q;
  logic                bit_end;

  always_comb begin
    last = LAST_BIT;
    if (state == ST_STOP) begin
      case (cfg_q.stop)
        STOP_ONE_HALF: last = LAST_HALF;
        STOP_TWO:      last = LAST_TWO;
        default:       last = LAST_ONE;
      endcase
    end
  end

  assign bit_end = tick && (cnt == last);
  assign take    = hold_full && ((state == ST_IDLE) || (state == ST_STOP && bit_end));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      bidx  <= '0;
      cfg_q <= '0;
    end else if (take) begin
      state <= ST_START;
      cnt   <= '0;
      sh    <= hold_data;
      bidx  <= '0;
      cfg_q <= cfg_in;
    end else if (state != ST_IDLE && tick) begin
      if (bit_end) begin
        cnt <= '0;
        case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            sh   <= sh >> 1;
            bidx <= bidx + 1'b1;
            if (bidx == cfg_q.nbits - 1'b1) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = sh[0];
      ST_PAR:   line = cfg_q.par_bit;
      default:  line = 1'b1;
    endcase
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/uart_fmt_tx.sv
module uart_fmt_tx
  import uft_pkg::*;
#(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [6:0]    line_ctl,
  input  logic          tick16,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          hold_empty,
  output logic          shift_empty
);
  logic          hold_full;
  logic [DW-1:0] hold_data;
  logic          take;
  logic          line;
  logic          busy;
  frame_cfg_t    cfg_next;

  uft_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .take(take), .hold_data(hold_data), .hold_full(hold_full)
  );

  uft_fmt_decode #(.DW(DW)) u_dec (
    .len_sel(line_ctl[1:0]), .long_stop(line_ctl[2]), .par_on(line_ctl[3]),
    .par_even(line_ctl[4]), .par_stuck(line_ctl[5]), .data(hold_data), .cfg(cfg_next)
  );

  uft_shift #(.DW(DW), .OS(OS)) u_shift (
    .clk(clk), .rst(rst), .tick(tick16), .hold_full(hold_full), .hold_data(hold_data),
    .cfg_in(cfg_next), .take(take), .line(line), .busy(busy)
  );

  assign txd         = line & ~line_ctl[6];
  assign hold_empty  = ~hold_full;
  assign shift_empty = ~busy;
endmodule

// File: rtl/uft_checker.sv
module uft_checker (
  input logic clk,
  input logic rst,
  input logic brk,
  input logic txd,
  input logic hold_empty,
  input logic shift_empty
);
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (rst)
    shift_empty && !brk |-> txd);

  a_r3_start_space: assert property (@(posedge clk) disable iff (rst)
    $fell(shift_empty) && !brk |-> !txd);

  a_r9_break_release: assert property (@(posedge clk) disable iff (rst)
    $fell(brk) && shift_empty |-> txd);

  a_r11_take_starts: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_empty) |-> !shift_empty);

  a_r13_drained_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(shift_empty) |-> hold_empty);
endmodule

bind uart_fmt_tx uft_checker u_chk (
  .clk(clk), .rst(rst), .brk(line_ctl[6]), .txd(txd),
  .hold_empty(hold_empty), .shift_empty(shift_empty)
);

// File: tb/tb_uart_fmt_tx.sv
`timescale 1ns/1ps
module tb_uart_fmt_tx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] line_ctl = '0;
  logic       tick16 = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, txd, hold_empty, shift_empty;

  int n_run = 0, n_fail = 0;
  int tick_div = 1, cyc = 0;
  logic last_tick = 1'b0;

  always #2.5 clk = ~clk;

  uart_fmt_tx dut (
    .clk(clk), .rst(rst), .line_ctl(line_ctl), .tick16(tick16),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    last_tick = tick16;
    cyc++;
    tick16 = ((cyc % tick_div) == 0);
  endtask

  function automatic int f_nbits(input logic [5:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic int f_stop(input logic [5:0] l);
    if (!l[2]) return 16;
    if (f_nbits(l) == 5) return 24;
    return 32;
  endfunction

  function automatic int f_body(input logic [5:0] l);
    return 16 * (1 + f_nbits(l) + int'(l[3]));
  endfunction

  function automatic int f_total(input logic [5:0] l);
    return f_body(l) + f_stop(l);
  endfunction

  function automatic string f_stop_req(input logic [5:0] l);
    if (!l[2]) return "R4";
    if (f_nbits(l) == 5) return "R5";
    return "R6";
  endfunction

  function automatic logic f_level(input logic [5:0] l, input logic [7:0] d, input int t);
    int b, ones;
    b = t / 16;
    if (b == 0) return 1'b0;
    if (b <= f_nbits(l)) return d[b-1];
    if (l[3] && b == f_nbits(l) + 1) begin
      if (l[5]) return ~l[4];
      ones = 0;
      for (int i = 0; i < f_nbits(l); i++) ones += int'(d[i]);
      return l[4] ? logic'(ones % 2) : logic'(1 - ones % 2);
    end
    return 1'b1;
  endfunction

  task automatic frame_check(input int tk, input int t1, input int t2,
                             input logic [5:0] l1, input logic [7:0] d1,
                             input logic [5:0] l2, input logic [7:0] d2,
                             input bit in_brk);
    int t;
    logic [5:0] l;
    logic [7:0] d;
    string dreq;
    if (in_brk) begin
      if (tk % 16 == 8) chk(txd == 1'b0, "R9 break", int'(txd), 0);
      return;
    end
    if (tk == t1 + t2) begin
      chk(txd == 1'b1, "R13 idle line", int'(txd), 1);
      chk(shift_empty == 1'b1, "R13 shift_empty after drain", int'(shift_empty), 1);
      return;
    end
    if (tk == t1 + t2 - 1) chk(shift_empty == 1'b0, "R13 busy in stop", int'(shift_empty), 0);
    if (tk < t1) begin t = tk; l = l1; d = d1; dreq = "R2"; end
    else begin t = tk - t1; l = l2; d = d2; dreq = "R12"; end
    if (t == 0) chk(txd == 1'b0, (tk == 0) ? "R3 start" : "R11 no gap", int'(txd), 0);
    else if (t < f_body(l) && t % 16 == 8) begin
      if (t / 16 > f_nbits(l))
        chk(txd == f_level(l, d, t), l[5] ? "R8 stuck parity" : "R7 parity",
            int'(txd), int'(f_level(l, d, t)));
      else
        chk(txd == f_level(l, d, t), (t < 16) ? "R3" : dreq, int'(txd), int'(f_level(l, d, t)));
    end else if (t == f_body(l) + 8)
      chk(txd == 1'b1, "R4 stop level", int'(txd), 1);
    else if (t == f_total(l) - 1)
      chk(txd == 1'b1, f_stop_req(l), int'(txd), 1);
  endtask

  task automatic run_pair(input logic [5:0] l1, input logic [7:0] d1,
                          input logic [5:0] l2, input logic [7:0] d2,
                          input int brk_on, input int brk_off, input int tdiv);
    int tk, since, last_chk, t1, t2, guard;
    bit started;
    tick_div = tdiv;
    guard = 0;
    while (!(shift_empty && hold_empty) && guard < 100) begin step(); guard++; end
    step();
    line_ctl = {1'b0, l1};
    wr_valid = 1'b1;
    wr_data  = d1;
    step();
    wr_data = d2;
    started = 0;
    guard = 0;
    while (!started && guard < 20) begin
      step(); #1;
      if (txd == 1'b0) started = 1;
      guard++;
    end
    chk(started, "R3 frame start", int'(started), 1);
    if (!started) return;
    chk(wr_ready == 1'b1, "R11 hold empty on take", int'(wr_ready), 1);
    t1 = f_total(l1);
    t2 = f_total(l2);
    tk = 0;
    since = 0;
    frame_check(0, t1, t2, l1, d1, l2, d2, 1'b0);
    last_chk = 0;
    while (last_chk < t1 + t2) begin
      step();
      since++;
      if (last_tick) tk++;
      line_ctl = {(tk >= brk_on && tk < brk_off), (tk >= 20) ? l2 : l1};
      if (tk >= 30 && tk < 40) begin
        wr_valid = 1'b1;
        wr_data  = ~d2;
      end else if (since >= 1) begin
        wr_valid = 1'b0;
      end
      #1;
      if (tk != last_chk) begin
        if (tk == 35) chk(wr_ready == 1'b0, "R10 not ready while held", int'(wr_ready), 0);
        frame_check(tk, t1, t2, l1, d1, l2, d2, (tk >= brk_on && tk < brk_off));
        last_chk = tk;
      end
    end
    line_ctl = '0;
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step(); #1;
    chk(txd == 1'b1, "R1 txd", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1 hold_empty", int'(hold_empty), 1);
    chk(shift_empty == 1'b1, "R1 shift_empty", int'(shift_empty), 1);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);

    // sweep of every format, format switched mid-frame (R12)
    for (int f = 0; f < 64; f++) begin
      run_pair(6'(f), 8'(8'hA5 ^ (f * 37)), 6'((f * 7 + 3) % 64), 8'(8'h3C ^ (f * 11)), -1, -1, 1);
    end

    // slow tick: timing counted in ticks, not clocks (R3)
    run_pair(6'h03, 8'h96, 6'h0C, 8'h1F, -1, -1, 3);
    run_pair(6'h2E, 8'h55, 6'h3B, 8'hC3, -1, -1, 3);

    // break over a frame of ones (R9)
    run_pair(6'h03, 8'hFF, 6'h03, 8'h5A, 24, 56, 1);
    run_pair(6'h1F, 8'hFF, 6'h00, 8'h0E, 8, 72, 1);

    // every byte value with 8-bit even parity (R7)
    for (int k = 0; k < 128; k++) begin
      run_pair(6'h1B, 8'(2 * k), 6'h1B, 8'(2 * k + 1), -1, -1, 1);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule